// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front-End

This block is the protocol engine that sits between a two-wire serial bus and the storage controller of an 8192-byte EEPROM. It sees SCL and SDA as levels already synchronised to the system clock. From them it finds START and STOP conditions and shifts in bytes MSB first. It acknowledges only select bytes that carry its type code and the value on its three strap inputs. It then collects a two-byte word address, hands write bytes to storage as single-cycle strobes, and serves read bytes from storage. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

Write bytes go into the current page and roll over inside it. A commit pulse on STOP tells the storage controller to start its internal write cycle. While that cycle runs, the controller raises a busy input and the front-end stops answering its select byte, so a master can poll for completion. Reads roll over across the whole array. A write-protect input blocks strobes to storage but leaves the bus exchange and all reads unchanged.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down request, the write strobe and the commit pulse are all low.
- R2: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. A byte sent after STOP without a new START is not acknowledged. The block asserts its SDA pull-down only while SCL is low.
- R3: The select byte is type code 1010 in bits 7..4, strap value in bits 3..1 and read (1) or write (0) in bit 0, sent MSB first. On a match the block pulls SDA low through the ninth SCL pulse. On a mismatch it stays silent and ignores the bus until the next START.
- R4: While the busy input is high, a matching select byte is not acknowledged.
- R5: After a write select, a high address byte and then a low address byte are each acknowledged. They form the word address {high[4:0], low}, and bits 7..5 of the high byte are ignored.
- R6: Each following data byte is acknowledged and produces one write strobe carrying its address and data. The address then advances in bits 4..0 only, wrapping inside the 32-byte page.
- R7: While write-protect is high, data bytes are acknowledged but no write strobe occurs. Reads still return stored data.
- R8: A STOP after at least one strobed write byte produces one commit pulse. A STOP with no strobed byte produces none.
- R9: A read select with no address phase returns data from the address after the last byte accessed.
- R10: A write select plus address, then a repeated START and a read select, returns data from that address.
- R11: While the master acknowledges, reading continues at successive addresses, wrapping from 8191 to 0.
- R12: After the master's NACK on a read byte, the block releases SDA before the next SCL pulse and awaits START.
- R13: A START in the middle of a byte abandons that byte, strobes nothing, and begins a new select phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (bus value) |
| sda_low_o | output | 1 | 1 requests the open-drain SDA pull-down |
| strap_i | input | 3 | Device address straps |
| wp_i | input | 1 | Write protect, active high |
| busy_i | input | 1 | Storage internal write cycle in progress |
| wr_valid_o | output | 1 | Single-cycle write strobe to storage |
| wr_addr_o | output | 13 | Address of strobed write byte |
| wr_data_o | output | 8 | Data of strobed write byte |
| commit_o | output | 1 | Single-cycle pulse: start internal write cycle |
| rd_addr_o | output | 13 | Current read address to storage |
| rd_data_i | input | 8 | Storage data at rd_addr_o |

## Verification
A wrong bit count or phase shows at the ports within one byte. The acknowledge pull-down either appears on a non-ninth pulse or is missing on the ninth, and the master's acknowledge check catches that on that byte. A corrupted address register does not show until a later strobe or read byte, where its address or data differs from the reference model. Wrap faults show only on the byte that crosses a page or the top of the array, so the sequences are placed to cross both. Faults in the protect or busy gating show as a strobe or acknowledge where none is allowed, and the write monitor flags it in the cycle it happens.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } tw_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/tw_line_cond.sv
module tw_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_word_addr.sv
module tw_word_addr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic [7:0]        byte_i,
  input  logic              inc_page_i,
  input  logic              inc_lin_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};

      a_r6_page_row_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_page_i |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
    end else begin : g_flat
      assign page_next = addr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else if (load_hi_i) begin
      hi_q <= byte_i[HI_W-1:0];
    end else if (load_lo_i) begin
      addr_q <= {hi_q, byte_i};
    end else if (inc_page_i) begin
      addr_q <= page_next;
    end else if (inc_lin_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  a_r11_top_wraps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_lin_i && !load_hi_i && !load_lo_i && !inc_page_i && addr_q == {ADDR_W{1'b1}})
      |=> addr_q == '0);
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_CLK  = 4'd9;

  logic rise, fall, start, stop;
  tw_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_sr, tx_sr;
  logic ack_q, out_q, load_pend, m_ack_q, rw_q, wrote_q;
  logic wr_valid_q, commit_q;
  logic [ADDR_W-1:0] wr_addr_q, addr;
  logic [7:0] wr_data_q;
  logic rx_phase, byte_done, ack_end, dev_hit;
  logic load_hi, load_lo, inc_page, inc_lin;

  tw_line_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (rise),
    .scl_fall_o (fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  assign rx_phase  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                     (state_q == ST_ALO) || (state_q == ST_WR);
  assign byte_done = fall && cnt_q == LAST_BIT;
  assign ack_end   = fall && cnt_q == ACK_CLK;
  assign dev_hit   = rx_sr[7:4] == DEV_CODE && rx_sr[3:1] == strap_i && !busy_i;

  assign load_hi  = byte_done && state_q == ST_AHI;
  assign load_lo  = byte_done && state_q == ST_ALO;
  assign inc_page = byte_done && state_q == ST_WR;
  assign inc_lin  = ack_end && state_q == ST_RD;

  tw_word_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_hi_i  (load_hi),
    .load_lo_i  (load_lo),
    .byte_i     (rx_sr),
    .inc_page_i (inc_page),
    .inc_lin_i  (inc_lin),
    .addr_o     (addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ack_q      <= 1'b0;
      out_q      <= 1'b0;
      load_pend  <= 1'b0;
      m_ack_q    <= 1'b0;
      rw_q       <= 1'b0;
      wrote_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      if (start) begin
        state_q   <= ST_DEV;
        cnt_q     <= '0;
        ack_q     <= 1'b0;
        out_q     <= 1'b0;
        load_pend <= 1'b0;
      end else if (stop) begin
        state_q   <= ST_IDLE;
        ack_q     <= 1'b0;
        out_q     <= 1'b0;
        load_pend <= 1'b0;
        commit_q  <= wrote_q;
        wrote_q   <= 1'b0;
      end else if (rx_phase) begin
        if (rise) begin
          if (cnt_q < LAST_BIT) begin
            rx_sr <= {rx_sr[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            cnt_q <= ACK_CLK;
          end
        end else if (byte_done) begin
          case (state_q)
            ST_DEV: begin
              if (dev_hit) begin
                ack_q <= 1'b1;
                rw_q  <= rx_sr[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_WR: begin
              ack_q <= 1'b1;
              if (!wp_i) begin
                wr_valid_q <= 1'b1;
                wr_addr_q  <= addr;
                wr_data_q  <= rx_sr;
                wrote_q    <= 1'b1;
              end
            end
            default: ack_q <= 1'b1;
          endcase
        end else if (ack_end) begin
          ack_q <= 1'b0;
          cnt_q <= '0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_q   <= ST_RD;
                load_pend <= 1'b1;
              end else begin
                state_q <= ST_AHI;
              end
            end
            ST_AHI:  state_q <= ST_ALO;
            ST_ALO:  state_q <= ST_WR;
            default: state_q <= ST_WR;
          endcase
        end
      end else if (state_q == ST_RD) begin
        if (load_pend) begin
          // address settled a cycle ago; storage data now valid
          load_pend <= 1'b0;
          tx_sr     <= rd_data_i;
          out_q     <= ~rd_data_i[7];
        end else if (rise) begin
          if (cnt_q == LAST_BIT) m_ack_q <= ~sda_i;
          if (cnt_q <= LAST_BIT) cnt_q <= cnt_q + 1'b1;
        end else if (fall) begin
          if (cnt_q >= 4'd1 && cnt_q < LAST_BIT) begin
            tx_sr <= {tx_sr[6:0], 1'b0};
            out_q <= ~tx_sr[6];
          end else if (cnt_q == LAST_BIT) begin
            out_q <= 1'b0;
          end else if (cnt_q == ACK_CLK) begin
            cnt_q <= '0;
            if (m_ack_q) load_pend <= 1'b1;
            else         state_q   <= ST_IDLE;
          end
        end
      end
    end
  end

  assign sda_low_o  = ack_q | out_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign commit_o   = commit_q;
  assign rd_addr_o  = addr;

  a_r2_pull_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_i);

  a_r13_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == '0 && !sda_low_o && state_q == ST_DEV));

  a_r4_busy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_DEV && busy_i) |=> !sda_low_o);

  a_r7_wp_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_WR && wp_i) |=> !wr_valid_o);

  a_r12_nack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_end && state_q == ST_RD && !m_ack_q) |=> (!sda_low_o && state_q == ST_IDLE));

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
endmodule

// File: tb/sim_tw_eeprom_slave.sv
module sim_tw_eeprom_slave;
  localparam int AW = 13;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_low, wr_valid, commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_m & ~sda_low;

  int checks = 0, failures = 0, commits = 0;
  bit done = 1'b0;

  logic [7:0] st_mem  [int];
  logic [7:0] ref_mem [int];
  logic [AW+7:0] exp_wr [$];
  logic [7:0] exp_rd [$];

  always #2 clk = ~clk;

  tw_eeprom_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_low_o(sda_low), .strap_i(strap), .wp_i(wp), .busy_i(busy),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .commit_o(commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 13) ^ (a >> 7) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] st_read(logic [AW-1:0] a);
    return st_mem.exists(int'(a)) ? st_mem[int'(a)] : init_val(int'(a));
  endfunction

  function automatic logic [7:0] ref_read(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  always_comb rd_data = st_read(rd_addr);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write monitor: storage model plus scoreboard compare
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      st_mem[int'(wr_addr)] = wr_data;
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R7/R13 unexpected write strobe", int'({wr_addr, wr_data}), 0);
      end else begin
        logic [AW+7:0] e;
        e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e, "R6 write strobe", int'({wr_addr, wr_data}), int'(e));
      end
    end
    if (rst_n && commit) commits++;
  end

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    ack = !sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic rd_byte(bit mack, string tag);
    logic [7:0] d;
    logic [7:0] e;
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      half(); scl_m = 1'b1; half();
      d = {d[6:0], sda_bus};
      scl_m = 1'b0;
    end
    sda_m = !mack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half();
    sda_m = 1'b1;
    e = exp_rd.pop_front();
    chk(d == e, tag, int'(d), int'(e));
  endtask

  task automatic exp_ack(logic [7:0] b, bit want, string tag);
    bit a;
    wr_byte(b, a);
    chk(a == want, tag, int'(a), int'(want));
  endtask

  task automatic push_wr(int a, logic [7:0] d);
    exp_wr.push_back({AW'(a), d});
    ref_mem[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk(sda_low == 1'b0, "R1 sda released", sda_low, 0);
    chk(wr_valid == 1'b0, "R1 no strobe", wr_valid, 0);
    chk(commit == 1'b0, "R1 no commit", commit, 0);
    rst_n = 1'b1;
    half();

    // page write with wrap, high address bits set but ignored
    do_start();
    exp_ack(8'hAA, 1, "R3 matching select ack");
    exp_ack(8'hE0, 1, "R5 high address ack");
    exp_ack(8'h3E, 1, "R5 low address ack");
    push_wr(16'h003E, 8'h11);
    exp_ack(8'h11, 1, "R6 data ack");
    push_wr(16'h003F, 8'h22);
    exp_ack(8'h22, 1, "R6 data ack");
    push_wr(16'h0020, 8'h33);
    exp_ack(8'h33, 1, "R6 data ack page wrap");
    c0 = commits;
    do_stop(); half();
    chk(commits == c0 + 1, "R8 commit after write", commits, c0 + 1);

    // busy: no ack
    busy = 1'b1;
    do_start();
    exp_ack(8'hAA, 0, "R4 busy select nack");
    do_stop();
    busy = 1'b0;

    // strap mismatch, rest of the transfer ignored
    do_start();
    exp_ack(8'hA2, 0, "R3 mismatch select nack");
    exp_ack(8'h55, 0, "R3 ignored until START");
    c0 = commits;
    do_stop(); half();
    chk(commits == c0, "R8 no commit without write", commits, c0);

    // byte without START after STOP
    exp_ack(8'hAA, 0, "R2 no ack without START");
    do_stop();

    // current address read
    do_start();
    exp_ack(8'hAB, 1, "R2 START then read select ack");
    exp_rd.push_back(ref_read(16'h0021));
    rd_byte(0, "R9 current address read");
    chk(sda_low == 1'b0, "R12 released after nack", sda_low, 0);
    do_stop();

    // random then sequential read across the top of the array
    do_start();
    exp_ack(8'hAA, 1, "R10 dummy write select");
    exp_ack(8'h1F, 1, "R10 high address");
    exp_ack(8'hFE, 1, "R10 low address");
    do_start();
    exp_ack(8'hAB, 1, "R10 read select");
    exp_rd.push_back(ref_read(16'h1FFE));
    rd_byte(1, "R10 random read");
    exp_rd.push_back(ref_read(16'h1FFF));
    rd_byte(1, "R11 sequential read");
    exp_rd.push_back(ref_read(0));
    rd_byte(0, "R11 wrap to zero");
    chk(sda_low == 1'b0, "R12 released after final nack", sda_low, 0);
    exp_ack(8'hFF, 0, "R12 idle after nack");
    do_stop();

    // write protect
    wp = 1'b1;
    do_start();
    exp_ack(8'hAA, 1, "R7 select under protect");
    exp_ack(8'h01, 1, "R7 high address");
    exp_ack(8'h00, 1, "R7 low address");
    exp_ack(8'h77, 1, "R7 data acked while protected");
    c0 = commits;
    do_stop(); half();
    chk(commits == c0, "R8 no commit when protected", commits, c0);
    do_start();
    exp_ack(8'hAA, 1, "R7 select");
    exp_ack(8'h01, 1, "R7 high address");
    exp_ack(8'h00, 1, "R7 low address");
    do_start();
    exp_ack(8'hAB, 1, "R7 read select");
    exp_rd.push_back(ref_read(16'h0100));
    rd_byte(0, "R7 read unchanged under protect");
    do_stop();
    wp = 1'b0;

    // START mid-byte
    do_start();
    for (int i = 0; i < 4; i++) send_bit(i[0] ? 1'b0 : 1'b1);
    do_start();
    exp_ack(8'hAA, 1, "R13 select after mid-byte START");
    exp_ack(8'h00, 1, "R13 high address");
    exp_ack(8'h05, 1, "R13 low address");
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    do_start();
    exp_ack(8'hAB, 1, "R13 read select after abort");
    exp_rd.push_back(ref_read(5));
    rd_byte(0, "R13 partial byte not written");
    c0 = commits;
    do_stop(); half();
    chk(commits == c0, "R13 no commit after abort", commits, c0);

    half();
    chk(exp_wr.size() == 0, "R6 all writes seen", exp_wr.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule